// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Selectable Status Flags

This block is the arithmetic core of a small accumulator processor. It combines an 8-bit arithmetic-logic unit with a 3-bit status register. The unit takes the accumulator, a second operand taken from the data bus, and a 3-bit operation code. It computes a result together with zero, carry and overflow indications. The control sequencer outside the block decodes instructions and drives the operation code and the enables. No decoding happens here.

The status register holds overflow, carry and zero. Each bit has its own 2:1 select. A select of 0 takes the flag the unit just produced. A select of 1 takes a fixed accumulator bit, which lets saved flags be written back through the accumulator. The shared data bus is modelled as plain input and output ports with an enable, not as tristate nets. The unit's result drives the bus only when its drive enable is high. A second drive enable places the status register on the bus.

Top module: `alu_status_unit`

## Requirements
- R1: Code 000 gives acc+opnd mod 256 with carry = carry out of bit 7. Code 001 gives acc−opnd mod 256 with carry = borrow (1 when acc < opnd, unsigned).
- R2: Code 010 gives AND, 011 gives OR and 100 gives XOR of acc and opnd. For these codes, carry and overflow are 0.
- R3: Code 101 gives acc+1, with carry 1 only when acc is 0xFF. Code 110 gives acc−1, with carry (borrow) 1 only when acc is 0x00. For both codes, opnd has no effect.
- R4: Overflow is signed two's-complement overflow for codes 000, 001, 101 and 110. It is 1 for increment only from 0x7F and for decrement only from 0x80.
- R5: For codes 000 to 110, the zero flag is 1 exactly when the 8-bit result is 0x00.
- R6: Code 111 passes acc through unchanged, and all three of its flags are 0, even when acc is 0x00.
- R7: The status register changes only on a clock edge where flag_load is high. On every other edge it keeps its value.
- R8: On a load, overflow takes acc bit 2 when sel_ovf is 1 and the unit's overflow otherwise. Carry takes acc bit 1 when sel_cy is 1 and the unit's carry otherwise. Zero takes acc bit 0 when sel_zf is 1 and the unit's zero flag otherwise.
- R9: With alu_drive high, bus_out carries the result in the same cycle. With only flag_drive high, bus_out carries {5'b0, overflow, carry, zero}: overflow in bit 2, carry in bit 1, zero in bit 0.
- R10: bus_en is the OR of the two drive enables. If both are high, the result wins. If neither is high, bus_out is 0x00.
- R11: While rst_n is low the status register is 0. rst_n is applied asynchronously and released on the second rising clock edge after it goes high.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc | input | 8 | Accumulator value |
| bus_in | input | 8 | Second operand from the data bus |
| op | input | 3 | Operation code |
| alu_drive | input | 1 | Place the result on the bus |
| flag_drive | input | 1 | Place the status register on the bus |
| flag_load | input | 1 | Load the status register at the clock edge |
| sel_ovf | input | 1 | Overflow source: 0 = unit, 1 = acc bit 2 |
| sel_cy | input | 1 | Carry source: 0 = unit, 1 = acc bit 1 |
| sel_zf | input | 1 | Zero source: 0 = unit, 1 = acc bit 0 |
| bus_out | output | 8 | Data driven onto the bus |
| bus_en | output | 1 | Bus is being driven |
| status | output | 3 | Status register {overflow, carry, zero} |

## Verification
The result and bus_en are combinational, so they are due in the same cycle as the stimulus. The bench applies inputs just after a falling edge and samples the bus a short delay later, before the next rising edge. The status register is due one rising edge after a cycle with flag_load high. The bench samples it just after that edge, against a model updated with the values that were present at the edge. Status seen through flag_drive reflects that model. The reset release is checked by waiting out the two-edge synchronizer before the first vector.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int DATA_W = 8;
  localparam int FLAG_W = 3;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_INC  = 3'b101,
    OP_DEC  = 3'b110,
    OP_PASS = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic cy;
    logic zf;
  } flags_t;
endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output flags_t       flg
);
  localparam int MSB = W - 1;
  localparam logic [W:0] ONE = (W+1)'(1);

  logic [W:0] ext;

  always_comb begin
    ext = '0;
    res = a;
    flg = '0;
    unique case (op)
      OP_ADD: begin
        ext     = {1'b0, a} + {1'b0, b};
        res     = ext[W-1:0];
        flg.cy  = ext[W];
        flg.ovf = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_SUB: begin
        ext     = {1'b0, a} - {1'b0, b};
        res     = ext[W-1:0];
        flg.cy  = ext[W];
        flg.ovf = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_INC: begin
        ext     = {1'b0, a} + ONE;
        res     = ext[W-1:0];
        flg.cy  = ext[W];
        flg.ovf = !a[MSB] && res[MSB];
      end
      OP_DEC: begin
        ext     = {1'b0, a} - ONE;
        res     = ext[W-1:0];
        flg.cy  = ext[W];
        flg.ovf = a[MSB] && !res[MSB];
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = a;
    endcase
    flg.zf = (op != OP_PASS) && (res == '0);
  end

  // Guards on the unit's flag contract
  always_comb begin
    if (!$isunknown({a, b, op})) begin
      if (op == OP_PASS)
        assert_pass_quiet_R6: assert (res == a && flg == '0);
      if (op == OP_AND || op == OP_OR || op == OP_XOR)
        assert_logic_no_arith_R2: assert (!flg.cy && !flg.ovf);
      if (op == OP_INC)
        assert_inc_ovf_R4: assert (flg.ovf == (a == {1'b0, {(W-1){1'b1}}}));
    end
  end
endmodule

// File: rtl/flag_status_reg.sv
module flag_status_reg
  import alu_flag_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int OVF_AB = 2,
  parameter int CY_AB  = 1,
  parameter int ZF_AB  = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         sel_ovf,
  input  logic         sel_cy,
  input  logic         sel_zf,
  input  flags_t       alu_flg,
  input  logic [W-1:0] acc,
  output flags_t       stat_q
);
  flags_t stat_d;

  always_comb begin
    stat_d     = stat_q;
    if (load) begin
      stat_d.ovf = sel_ovf ? acc[OVF_AB] : alu_flg.ovf;
      stat_d.cy  = sel_cy  ? acc[CY_AB]  : alu_flg.cy;
      stat_d.zf  = sel_zf  ? acc[ZF_AB]  : alu_flg.zf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_q <= '0;
    else if (load) stat_q <= stat_d;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(stat_q));
  assert_zf_from_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sel_zf) |=> (stat_q.zf == $past(acc[ZF_AB])));
  assert_cy_from_alu_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sel_cy) |=> (stat_q.cy == $past(alu_flg.cy)));
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] bus_in,
  input  logic [2:0]   op,
  input  logic         alu_drive,
  input  logic         flag_drive,
  input  logic         flag_load,
  input  logic         sel_ovf,
  input  logic         sel_cy,
  input  logic         sel_zf,
  output logic [W-1:0] bus_out,
  output logic         bus_en,
  output logic [2:0]   status
);
  logic         rst_n_s;
  logic [W-1:0] alu_res;
  flags_t       alu_flg;
  flags_t       stat_q;

  rst_release_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  flag_alu #(.W(W)) u_alu (
    .a(acc), .b(bus_in), .op(alu_op_e'(op)), .res(alu_res), .flg(alu_flg)
  );

  flag_status_reg #(.W(W)) u_stat (
    .clk(clk), .rst_n(rst_n_s), .load(flag_load),
    .sel_ovf(sel_ovf), .sel_cy(sel_cy), .sel_zf(sel_zf),
    .alu_flg(alu_flg), .acc(acc), .stat_q(stat_q)
  );

  always_comb begin
    if (alu_drive)       bus_out = alu_res;
    else if (flag_drive) bus_out = {{(W-FLAG_W){1'b0}}, stat_q};
    else                 bus_out = '0;
  end

  assign bus_en = alu_drive | flag_drive;
  assign status = stat_q;

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_en |-> (bus_out == '0));
  assert_flag_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (flag_drive && !alu_drive) |-> (bus_out[W-1:FLAG_W] == '0));
endmodule

// File: tb/alu_status_unit_test.sv
module alu_status_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] acc, bus_in;
  logic [2:0] op;
  logic       alu_drive, flag_drive, flag_load, sel_ovf, sel_cy, sel_zf;
  logic [7:0] bus_out;
  logic       bus_en;
  logic [2:0] status;

  int n_vec = 0;
  int n_bad = 0;
  logic [2:0] model_stat;
  bit done = 0;

  alu_status_unit uut (
    .clk(clk), .rst_n(rst_n), .acc(acc), .bus_in(bus_in), .op(op),
    .alu_drive(alu_drive), .flag_drive(flag_drive), .flag_load(flag_load),
    .sel_ovf(sel_ovf), .sel_cy(sel_cy), .sel_zf(sel_zf),
    .bus_out(bus_out), .bus_en(bus_en), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Returns {result, ovf, cy, zf}
  function automatic logic [10:0] ref_alu(input logic [7:0] a, b, input logic [2:0] o);
    int ua, ub, r;
    logic c, v, z;
    logic [7:0] res;
    ua = int'(a); ub = int'(b); c = 0; v = 0;
    case (o)
      3'd0: begin r = ua + ub; c = r > 255; end
      3'd1: begin r = ua - ub; c = ua < ub; end
      3'd2: r = int'(a & b);
      3'd3: r = int'(a | b);
      3'd4: r = int'(a ^ b);
      3'd5: begin r = ua + 1; c = (ua == 255); end
      3'd6: begin r = ua - 1; c = (ua == 0); end
      default: r = ua;
    endcase
    res = r[7:0];
    case (o)
      3'd0: v = (a[7] == b[7]) && (res[7] != a[7]);
      3'd1: v = (a[7] != b[7]) && (res[7] != a[7]);
      3'd5: v = (a == 8'h7F);
      3'd6: v = (a == 8'h80);
      default: v = 0;
    endcase
    z = (o != 3'd7) && (res == 8'h00);
    return {res, v, c, z};
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R1/R4/R5";
      3'd2, 3'd3, 3'd4: return "R2/R5";
      3'd5, 3'd6: return "R3/R4/R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] a, b, input logic [2:0] o,
                      input logic ad, fd, ld, so, sc, sz);
    logic [10:0] r;
    logic [7:0] exp_bus;
    @(negedge clk);
    acc = a; bus_in = b; op = o; alu_drive = ad; flag_drive = fd;
    flag_load = ld; sel_ovf = so; sel_cy = sc; sel_zf = sz;
    r = ref_alu(a, b, o);
    #1;
    if (ad) exp_bus = r[10:3];
    else if (fd) exp_bus = {5'b0, model_stat};
    else exp_bus = 8'h00;
    if (ad) check({tag_of(o), " R9/R10 result on bus"}, {8'h0, bus_out}, {8'h0, exp_bus});
    else check("R9/R10 bus contents", {8'h0, bus_out}, {8'h0, exp_bus});
    check("R10 bus_en", {15'h0, bus_en}, {15'h0, ad | fd});
    @(posedge clk);
    #1;
    if (ld) model_stat = {so ? a[2] : r[2], sc ? a[1] : r[1], sz ? a[0] : r[0]};
    check(ld ? {tag_of(o), " R8 status load"} : "R7 status hold",
          {13'h0, status}, {13'h0, model_stat});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; acc = 0; bus_in = 0; op = 0; alu_drive = 0; flag_drive = 0;
    flag_load = 1; sel_ovf = 0; sel_cy = 0; sel_zf = 0;
    model_stat = 3'b000;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset status", {13'h0, status}, 16'h0);
    @(negedge clk); rst_n = 1'b1; flag_load = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 status after release", {13'h0, status}, 16'h0);

    // Directed corners
    step(8'h7F, 8'h01, 3'd0, 1, 0, 1, 0, 0, 0); // add signed overflow
    step(8'hFF, 8'h01, 3'd0, 1, 0, 1, 0, 0, 0); // add carry, zero
    step(8'h00, 8'h01, 3'd1, 1, 0, 1, 0, 0, 0); // sub borrow
    step(8'h80, 8'h01, 3'd1, 1, 0, 1, 0, 0, 0); // sub overflow
    step(8'hFF, 8'h55, 3'd5, 1, 0, 1, 0, 0, 0); // inc wrap, R3 opnd ignored
    step(8'h7F, 8'hAA, 3'd5, 1, 0, 1, 0, 0, 0); // inc overflow
    step(8'h00, 8'h33, 3'd6, 1, 0, 1, 0, 0, 0); // dec borrow
    step(8'h80, 8'h00, 3'd6, 1, 0, 1, 0, 0, 0); // dec overflow
    step(8'hF0, 8'h0F, 3'd2, 1, 0, 1, 0, 0, 0); // AND zero
    step(8'hF0, 8'h0F, 3'd3, 1, 0, 1, 0, 0, 0); // OR
    step(8'hFF, 8'hFF, 3'd4, 1, 0, 1, 0, 0, 0); // XOR zero
    step(8'h00, 8'h12, 3'd7, 1, 0, 1, 0, 0, 0); // R6 pass, zero flag 0
    step(8'h07, 8'h00, 3'd7, 0, 1, 1, 1, 1, 1); // R8 all from acc
    step(8'h00, 8'h00, 3'd0, 0, 1, 0, 0, 0, 0); // R7 hold, R9 flags on bus
    step(8'h05, 8'h05, 3'd1, 0, 1, 0, 0, 0, 0); // R7 hold under zero result
    step(8'h12, 8'h34, 3'd0, 1, 1, 0, 0, 0, 0); // R10 both drives
    step(8'h12, 8'h34, 3'd0, 0, 0, 0, 0, 0, 0); // R10 idle bus
    step(8'h02, 8'hFF, 3'd0, 0, 1, 1, 1, 0, 1); // R8 mixed select
    step(8'h00, 8'h00, 3'd0, 0, 1, 0, 0, 0, 0); // read back mixed

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] dr;
      dr = 4'($urandom_range(0, 15));
      step(8'($urandom), 8'($urandom), 3'($urandom_range(0, 7)),
           dr < 4'd11, dr[0], 1'($urandom), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule